// File: doc/BRIEF.md
# Relay Permit Gate with Readback Supervision

This block sits between a safety controller and a normally-open enable coil. It drives the coil from a plain AND of two separate permissives: the controller's enable command and the hardwired key-switch "armed" discrete. The drive path contains no register that software can write, so no software state can hold the coil on. A de-energised coil leaves the actuator inhibited, which makes the de-energised state the safe one.

Alongside the drive, two cycle counters compare a readback of the coil or contact state with the commanded state. If the readback stays energised too long after the drive has dropped, a stuck-on fault latches. If the readback fails to show energised within a settle window after the drive has risen, a stuck-off fault latches. Both flags go back to the controller. A synchronous reset clears them only while the readback shows the coil released. The fault flags do not feed back into the drive path.

Top module: `relay_permit_gate`

## Requirements
- R1: `coil_drive` is 1 in the same cycle exactly when `en_cmd`, `key_armed` are both 1 and `rst` is 0, with no clock edge between input and output.
- R2: When either permissive drops, `coil_drive` falls combinationally in that same cycle, well inside the 10 ms release budget.
- R3: While `coil_drive` is 0 and `coil_fb` is 1, `stuck_on_flt` stays 0 for OFF_BUDGET consecutive rising edges (default 40) and becomes 1 after the next such edge.
- R4: While `coil_drive` is 1 and `coil_fb` is 0, `stuck_off_flt` stays 0 for ON_SETTLE consecutive rising edges (default 20) and becomes 1 after the next such edge.
- R5: A single edge at which readback agrees with the drive restarts that direction's count from zero.
- R6: Once set, each fault flag stays 1 whatever the inputs do, until a clearing reset.
- R7: An edge with `rst`=1 and `coil_fb`=0 clears both flags. An edge with `rst`=1 and `coil_fb`=1 leaves both flags unchanged.
- R8: While `rst` is 1, `coil_drive` is 0 whatever the permissives are.
- R9: The fault flags have no effect on `coil_drive`. With a flag set, both permissives high still give a drive of 1.
- R10: Reset zeroes both counts. A mismatch that starts after reset gets a full fresh window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the supervision counters |
| rst | input | 1 | Synchronous active-high reset; also blocks the drive |
| en_cmd | input | 1 | Enable command from the safety controller |
| key_armed | input | 1 | Hardwired key-switch armed discrete |
| coil_fb | input | 1 | Readback of coil/contact state, 1 = energised |
| coil_drive | output | 1 | Coil drive, 1 = energise |
| stuck_on_flt | output | 1 | Latched fault: readback stayed energised after release |
| stuck_off_flt | output | 1 | Latched fault: readback never showed energised after drive |

## Verification
The assertions take `coil_fb` to be already synchronous to `clk`, changing only between edges. They also assume that reset is held for at least one edge before checking starts. The bench drives every input on the falling edge, so each value is stable across the rising edge it affects. It begins with a reset edge while the readback is low. In its random phase the readback follows the drive with random lag, and at times it is forced high or low. This produces both short mismatches and windows long enough to trip a flag, while staying inside those assumptions.

// File: rtl/relay_permit_pkg.sv
package relay_permit_pkg;

    localparam int unsigned DEF_OFF_BUDGET = 40;
    localparam int unsigned DEF_ON_SETTLE  = 20;

    typedef struct packed {
        logic stuck_on;
        logic stuck_off;
    } flt_t;

    typedef struct packed {
        logic mis_off;  // drive low, readback high
        logic mis_on;   // drive high, readback low
    } mismatch_t;

    function automatic mismatch_t classify(input logic drive, input logic fb);
        mismatch_t m;
        m.mis_off = !drive && fb;
        m.mis_on  = drive && !fb;
        return m;
    endfunction

endpackage

// File: rtl/permit_and.sv
module permit_and (
    input  logic rst,
    input  logic en_cmd,
    input  logic key_armed,
    output logic drive
);
    // Pure combinational permissive path: no state anywhere.
    always_comb begin
        drive = en_cmd & key_armed & ~rst;
    end
endmodule

// File: rtl/mismatch_timer.sv
module mismatch_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fb_low,
    input  logic mismatch,
    output logic flag
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;
    logic          flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            if (fb_low) flag_q <= 1'b0;
        end else if (mismatch) begin
            if (cnt == LIM) flag_q <= 1'b1;
            else            cnt    <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/relay_permit_gate.sv
module relay_permit_gate
    import relay_permit_pkg::*;
#(
    parameter int unsigned OFF_BUDGET = DEF_OFF_BUDGET,
    parameter int unsigned ON_SETTLE  = DEF_ON_SETTLE
) (
    input  logic clk,
    input  logic rst,
    input  logic en_cmd,
    input  logic key_armed,
    input  logic coil_fb,
    output logic coil_drive,
    output logic stuck_on_flt,
    output logic stuck_off_flt
);
    logic      drv;
    mismatch_t mis;
    flt_t      flt;

    permit_and u_and (
        .rst       (rst),
        .en_cmd    (en_cmd),
        .key_armed (key_armed),
        .drive     (drv)
    );

    always_comb mis = classify(drv, coil_fb);

    mismatch_timer #(.LIMIT(OFF_BUDGET)) u_off (
        .clk      (clk),
        .rst      (rst),
        .fb_low   (~coil_fb),
        .mismatch (mis.mis_off),
        .flag     (flt.stuck_on)
    );

    mismatch_timer #(.LIMIT(ON_SETTLE)) u_on (
        .clk      (clk),
        .rst      (rst),
        .fb_low   (~coil_fb),
        .mismatch (mis.mis_on),
        .flag     (flt.stuck_off)
    );

    assign coil_drive    = drv;
    assign stuck_on_flt  = flt.stuck_on;
    assign stuck_off_flt = flt.stuck_off;
endmodule

// File: rtl/relay_permit_gate_chk.sv
module relay_permit_gate_chk (
    input logic clk,
    input logic rst,
    input logic en_cmd,
    input logic key_armed,
    input logic coil_fb,
    input logic coil_drive,
    input logic stuck_on_flt,
    input logic stuck_off_flt
);
    // R1: no key, no drive
    p_no_drive_without_key_r1: assert property (@(posedge clk) disable iff (rst)
        !key_armed |-> !coil_drive);

    // R6: flags are sticky outside reset
    p_on_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        stuck_on_flt |=> stuck_on_flt);
    p_off_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        stuck_off_flt |=> stuck_off_flt);

    // R3: stuck-on only rises after a released-but-energised sample
    p_on_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(stuck_on_flt) |-> $past(!coil_drive && coil_fb));

    // R4: stuck-off only rises after a driven-but-released sample
    p_off_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(stuck_off_flt) |-> $past(coil_drive && !coil_fb));

    // R7: clearing needs reset with readback low
    p_clear_needs_fb_low_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(stuck_on_flt) |-> $past(rst && !coil_fb));
endmodule

bind relay_permit_gate relay_permit_gate_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .en_cmd        (en_cmd),
    .key_armed     (key_armed),
    .coil_fb       (coil_fb),
    .coil_drive    (coil_drive),
    .stuck_on_flt  (stuck_on_flt),
    .stuck_off_flt (stuck_off_flt)
);

// File: tb/sim_relay_permit_gate.sv
`timescale 1ns/1ps
module sim_relay_permit_gate;
    localparam int OFFB = 40;
    localparam int ONS  = 20;

    logic clk = 1'b0;
    logic rst, en_cmd, key_armed, coil_fb;
    logic coil_drive, stuck_on_flt, stuck_off_flt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    int  m_off_c, m_on_c;
    bit  m_son, m_soff;

    always #2.5 clk = ~clk;

    relay_permit_gate #(.OFF_BUDGET(OFFB), .ON_SETTLE(ONS)) u0 (
        .clk(clk), .rst(rst), .en_cmd(en_cmd), .key_armed(key_armed),
        .coil_fb(coil_fb), .coil_drive(coil_drive),
        .stuck_on_flt(stuck_on_flt), .stuck_off_flt(stuck_off_flt)
    );

    function automatic bit exp_drive(bit r, bit e, bit k);
        return e && k && !r;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge(bit r, bit d, bit fb);
        if (r) begin
            m_off_c = 0; m_on_c = 0;
            if (!fb) begin m_son = 0; m_soff = 0; end
        end else begin
            if (!d && fb) begin
                if (m_off_c == OFFB) m_son = 1; else m_off_c++;
            end else m_off_c = 0;
            if (d && !fb) begin
                if (m_on_c == ONS) m_soff = 1; else m_on_c++;
            end else m_on_c = 0;
        end
    endtask

    // called right after a negedge: apply, check drive, clock, check flags
    task automatic step(bit r, bit e, bit k, bit fb, string req);
        bit d;
        rst = r; en_cmd = e; key_armed = k; coil_fb = fb;
        d = exp_drive(r, e, k);
        #1;
        chk({req, " drive R1"}, coil_drive, d);
        @(posedge clk);
        model_edge(r, d, fb);
        @(negedge clk);
        chk({req, " stuck_on"}, stuck_on_flt, m_son);
        chk({req, " stuck_off"}, stuck_off_flt, m_soff);
    endtask

    task automatic steps(int n, bit r, bit e, bit k, bit fb, string req);
        for (int i = 0; i < n; i++) step(r, e, k, fb, req);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_off_c = 0; m_on_c = 0; m_son = 0; m_soff = 0;
        rst = 1; en_cmd = 0; key_armed = 0; coil_fb = 0;
        void'($urandom(32'h5A17));
        @(negedge clk);
        steps(2, 1, 0, 0, 0, "reset R7");
        // R8: reset blocks drive even with both permissives
        step(1, 1, 1, 0, "R8");
        // R1 truth table
        step(0, 0, 0, 0, "R1 00");
        step(0, 1, 0, 0, "R1 10");
        step(0, 0, 1, 0, "R1 01");
        step(0, 1, 1, 1, "R1 11");
        // R2: withdraw enable, drive falls same cycle
        step(0, 0, 1, 0, "R2");
        // R3 boundary: OFFB mismatched edges no flag, next sets it
        steps(OFFB, 0, 0, 1, 1, "R3 window");
        chk("R3 before limit", stuck_on_flt, 1'b0);
        step(0, 0, 1, 1, "R3 trip");
        chk("R3 tripped", stuck_on_flt, 1'b1);
        // R6: stays set after agreement returns
        steps(5, 0, 0, 0, 0, "R6");
        chk("R6 held", stuck_on_flt, 1'b1);
        // R7: reset with fb high keeps flag
        step(1, 0, 0, 1, "R7 fb high");
        chk("R7 kept", stuck_on_flt, 1'b1);
        // R7: reset with fb low clears
        step(1, 0, 0, 0, "R7 fb low");
        chk("R7 cleared", stuck_on_flt, 1'b0);
        // R5: streak broken one short of limit, restart
        steps(ONS, 0, 1, 1, 0, "R5 a");
        step(0, 1, 1, 1, "R5 break");
        steps(ONS, 0, 1, 1, 0, "R5 b");
        chk("R5 no trip", stuck_off_flt, 1'b0);
        step(0, 1, 1, 0, "R4 trip");
        chk("R4 tripped", stuck_off_flt, 1'b1);
        // R9: flag does not block drive
        step(0, 1, 1, 1, "R9");
        // R10: reset then fresh full window
        step(1, 0, 0, 0, "R10 rst");
        steps(ONS - 1, 0, 1, 1, 0, "R10 a");
        step(1, 0, 0, 0, "R10 rst2");
        steps(ONS, 0, 1, 1, 0, "R10 b");
        chk("R10 fresh window", stuck_off_flt, 1'b0);
        step(1, 0, 0, 0, "R10 clr");
        // random phase
        begin
            bit fbv = 0;
            for (int i = 0; i < 4000; i++) begin
                bit r  = ($urandom_range(99) < 2);
                bit e  = ($urandom_range(99) < 70);
                bit k  = ($urandom_range(99) < 80);
                int mode = $urandom_range(99);
                bit d  = exp_drive(r, e, k);
                if (mode < 80) begin
                    if ($urandom_range(3) == 0) fbv = d;
                end else if (mode < 90) fbv = 1;
                else fbv = 0;
                step(r, e, k, fbv, "random R3/R4/R6");
            end
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule